// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that lets a host controller read and write a small bank of byte-wide configuration registers. The register contents leave the block as one flat parallel bus, and the chip uses them as enables for its clock output buffers. The block samples the clock and data lines through synchronizers. It answers only to its own 7-bit device address, and it pulls the data line low through an open-drain enable. It never drives the line high.

The command byte selects one of two access kinds. With bit 7 set, the transfer is a single indexed byte, and bits 6:0 give the register offset. With bit 7 clear, the transfer is a block transfer that starts at register 0 and moves upward. A block write carries a byte-count byte, which the slave accepts and then discards. A block read opens with a byte count that the slave supplies itself. Bit 0 of the last register removes the count byte from both directions. The master may stop after any whole byte, and bytes written before the stop keep their values.

Top module: `smb_cfg_slave`

## Requirements
- R1: When reset is released, register i holds byte i of REG_DEFAULTS (bits 8i+7:8i of `cfg_o`), and `sda_oe` is 0.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) an address byte of 0xD2 (address 1101001, write) or 0xD3 (read).
- R3: After any other address byte, the slave does not acknowledge. It then leaves SDA released and writes nothing until the next start condition.
- R4: In a write, a command byte with bit 7 = 1 selects the register at offset bits 6:0. The next data byte is stored there and acknowledged.
- R5: A byte read (write address, command with bit 7 = 1, repeated start, read address) returns the register at the command offset, most significant bit first.
- R6: In a write, a command byte with bit 7 = 0 starts a block write. The slave acknowledges the following byte-count byte and does not store it. The data bytes after it go to registers 0, 1, 2 and upward, and each is acknowledged.
- R7: A block read (command with bit 7 = 0, then a repeated start and the read address) first returns a count byte equal to NUM_REGS. It then returns the registers from 0 upward for as long as the master acknowledges.
- R8: While bit 0 of the last register is 1, block transfers have no count byte. A block write stores its first data byte in register 0, and a block read returns register 0 first.
- R9: A stop after any whole byte ends the transfer. Registers written before the stop keep their new values, and the rest stay unchanged.
- R10: In a block transfer, the register after the last one is register 0. Write bytes past the last register are acknowledged and discarded, while reads continue at register 0. A byte write to an offset of NUM_REGS or more is acknowledged and discarded, and a byte read from such an offset returns 0x00.
- R11: The slave changes `sda_oe` only while SCL is low, and it has SDA released right after any start or stop condition.
- R12: `cfg_o` changes only at the acknowledge of a data byte. Address, command and count bytes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset, loads the register defaults |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | NUM_REGS*8 | Register contents, register i at bits 8i+7:8i |

## Verification
The assertions check on every cycle the bus-level rules that apply in any transfer. The data line may move only while SCL is low, and the slave begins to drive only after a detected falling clock edge. After every start and stop the line is released, and the configuration outputs change only while a data byte is being acknowledged. What the bench scenarios must show is which byte lands where and what comes back: offset decoding, the count byte and its suppression bit, address rejection, wrap past the last register, and early stops. Those results depend on the order of whole transactions, and no single-cycle property can see it.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    localparam int OFF_W = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_CNT,
        S_WDATA,
        S_RXACK,
        S_TX,
        S_TXACK,
        S_IGNORE
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e       st;
        ctl_state_e       nxt;
        logic [3:0]       bcnt;
        logic [7:0]       sh;
        logic [OFF_W-1:0] ptr;
        logic             cnt_first;
        logic             wrapped;
        logic             mack;
        logic             oe;
    } ctl_t;

endpackage

// File: rtl/smb_bus_sync.sv
module smb_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    localparam int TAP = STAGES - 1;

    // one extra stage beyond the synchronizer holds the previous value
    logic [STAGES:0] scl_q, scl_d;
    logic [STAGES:0] sda_q, sda_d;

    always_comb begin
        scl_d = {scl_q[STAGES-1:0], scl_i};
        sda_d = {sda_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        scl_now   = scl_q[TAP];
        scl_old   = scl_q[STAGES];
        sda_now   = sda_q[TAP];
        sda_old   = sda_q[STAGES];
        sda_s     = sda_now;
        scl_rise  = scl_now && !scl_old;
        scl_fall  = !scl_now && scl_old;
        bus_start = scl_now && scl_old && sda_old && !sda_now;
        bus_stop  = scl_now && scl_old && !sda_old && sda_now;
    end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                    NUM_REGS = 8,
    parameter int                    OFF_W    = 7,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [OFF_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        logic [7:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && (wr_idx == OFF_W'(gi))) begin
                r_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= DEFAULTS[gi*8 +: 8];
            end else begin
                r_q <= r_d;
            end
        end

        assign regs_o[gi*8 +: 8] = r_q;
    end

    // offsets with no register behind them read as zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == OFF_W'(i)) begin
                rd_data = regs_o[i*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int                    NUM_REGS     = 8,
    parameter logic [6:0]            DEV_ADDR     = 7'h69,
    parameter int                    SYNC_STAGES  = 2,
    parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 64'h005A_C3FF_F00F_FF81
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);

    localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(NUM_REGS - 1);
    localparam logic [7:0]       CNT_BYTE = 8'(NUM_REGS);
    localparam int               SKIP_POS = (NUM_REGS - 1) * 8;

    localparam ctl_t CTL_RST = '{
        st: S_IDLE, nxt: S_IDLE, bcnt: '0, sh: '0, ptr: '0,
        cnt_first: 1'b0, wrapped: 1'b0, mack: 1'b0, oe: 1'b0
    };

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    smb_bus_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    ctl_t ctl_d, ctl_q;

    logic             wr_en;
    logic [OFF_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;

    smb_reg_bank #(
        .NUM_REGS(NUM_REGS),
        .OFF_W   (OFF_W),
        .DEFAULTS(REG_DEFAULTS)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (ctl_q.ptr),
        .rd_data(rd_data),
        .regs_o (cfg_o)
    );

    logic             skip_cnt;
    logic             byte_done;
    logic             in_range;
    logic [7:0]       load_byte;
    logic [OFF_W-1:0] adv_ptr;
    logic             adv_wrap;

    always_comb begin
        skip_cnt  = cfg_o[SKIP_POS];
        byte_done = (ctl_q.bcnt == 4'd8);
        in_range  = (ctl_q.ptr <= LAST_IDX) && !ctl_q.wrapped;
        load_byte = ctl_q.cnt_first ? CNT_BYTE : rd_data;
        adv_ptr   = (ctl_q.ptr >= LAST_IDX) ? '0 : ctl_q.ptr + OFF_W'(1);
        adv_wrap  = ctl_q.wrapped || (ctl_q.ptr >= LAST_IDX);
        wr_idx    = ctl_q.ptr;
        wr_data   = ctl_q.sh;
    end

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (bus_stop) begin
            ctl_d.st = S_IDLE;
            ctl_d.oe = 1'b0;
        end else if (bus_start) begin
            ctl_d.st   = S_ADDR;
            ctl_d.bcnt = '0;
            ctl_d.oe   = 1'b0;
        end else begin
            unique case (ctl_q.st)
                S_ADDR, S_CMD, S_CNT, S_WDATA: begin
                    if (scl_rise && !byte_done) begin
                        ctl_d.sh   = {ctl_q.sh[6:0], sda_s};
                        ctl_d.bcnt = ctl_q.bcnt + 4'd1;
                    end else if (scl_fall && byte_done) begin
                        ctl_d.oe   = 1'b1;
                        ctl_d.st   = S_RXACK;
                        ctl_d.bcnt = '0;
                        case (ctl_q.st)
                            S_ADDR: begin
                                if (ctl_q.sh[7:1] == DEV_ADDR) begin
                                    ctl_d.nxt = ctl_q.sh[0] ? S_TX : S_CMD;
                                end else begin
                                    ctl_d.oe = 1'b0;
                                    ctl_d.st = S_IGNORE;
                                end
                            end
                            S_CMD: begin
                                ctl_d.wrapped = 1'b0;
                                if (ctl_q.sh[7]) begin
                                    ctl_d.ptr       = ctl_q.sh[6:0];
                                    ctl_d.cnt_first = 1'b0;
                                    ctl_d.nxt       = S_WDATA;
                                end else begin
                                    ctl_d.ptr       = '0;
                                    ctl_d.cnt_first = !skip_cnt;
                                    ctl_d.nxt       = skip_cnt ? S_WDATA : S_CNT;
                                end
                            end
                            S_CNT: begin
                                ctl_d.nxt = S_WDATA;
                            end
                            default: begin
                                wr_en         = in_range;
                                ctl_d.ptr     = adv_ptr;
                                ctl_d.wrapped = adv_wrap;
                                ctl_d.nxt     = S_WDATA;
                            end
                        endcase
                    end
                end
                S_RXACK: begin
                    if (scl_fall) begin
                        ctl_d.oe   = 1'b0;
                        ctl_d.bcnt = '0;
                        if (ctl_q.nxt == S_TX) begin
                            ctl_d.st = S_TX;
                            ctl_d.sh = load_byte;
                            ctl_d.oe = !load_byte[7];
                            if (ctl_q.cnt_first) begin
                                ctl_d.cnt_first = 1'b0;
                            end else begin
                                ctl_d.ptr     = adv_ptr;
                                ctl_d.wrapped = adv_wrap;
                            end
                        end else begin
                            ctl_d.st = ctl_q.nxt;
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise && !byte_done) begin
                        ctl_d.bcnt = ctl_q.bcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (byte_done) begin
                            ctl_d.oe = 1'b0;
                            ctl_d.st = S_TXACK;
                        end else begin
                            ctl_d.sh = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.oe = !ctl_q.sh[6];
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        ctl_d.mack = !sda_s;
                    end else if (scl_fall) begin
                        ctl_d.bcnt = '0;
                        if (ctl_q.mack) begin
                            ctl_d.st = S_TX;
                            ctl_d.sh = load_byte;
                            ctl_d.oe = !load_byte[7];
                            if (ctl_q.cnt_first) begin
                                ctl_d.cnt_first = 1'b0;
                            end else begin
                                ctl_d.ptr     = adv_ptr;
                                ctl_d.wrapped = adv_wrap;
                            end
                        end else begin
                            ctl_d.st = S_IGNORE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe = ctl_q.oe;

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  scl_fall,
    input logic                  bus_start,
    input logic                  bus_stop
);

    assert_sda_moves_low_scl_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i
    );

    assert_drive_after_fall_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)
    );

    assert_release_on_stop_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe
    );

    assert_release_on_start_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        bus_start |=> !sda_oe
    );

    assert_cfg_only_at_ack_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> (sda_oe && $past(scl_fall))
    );

endmodule

bind smb_cfg_slave smb_cfg_checker #(
    .NUM_REGS(NUM_REGS)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .cfg_o    (cfg_o),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
);

// File: tb/test_smb_cfg_slave.sv
`timescale 1ns/1ps
module test_smb_cfg_slave;

    localparam int NUM_REGS = 8;
    localparam int Q        = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NUM_REGS*8-1:0] cfg_o;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_cfg_slave i_smb_cfg_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_m),
        .sda_i (sda_line),
        .sda_oe(sda_oe),
        .cfg_o (cfg_o)
    );

    int checks = 0;
    int failures = 0;
    logic [7:0] model [NUM_REGS];

    int    exp_val_q [$];
    string exp_tag_q [$];
    int    obs_q     [$];

    // monitor: pairs each observed bus result with the expectation queued for it
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() != 0) begin
                int o;
                o = obs_q.pop_front();
                checks++;
                if (exp_val_q.size() == 0) begin
                    failures++;
                    $display("FAIL scoreboard: unexpected item actual=%0h expected=none", o);
                end else begin
                    int e;
                    string t;
                    e = exp_val_q.pop_front();
                    t = exp_tag_q.pop_front();
                    if (o != e) begin
                        failures++;
                        $display("FAIL %s: actual=%0h expected=%0h", t, o, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(string tag);
        for (int i = 0; i < NUM_REGS; i++) begin
            check($sformatf("%s reg%0d", tag, i), int'(cfg_o[i*8 +: 8]), int'(model[i]));
        end
    endtask

    task automatic waitq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start_cond();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop_cond();
        waitq(3);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(Q);
    endtask

    task automatic put_bit(logic b);
        waitq(3);
        sda_m = b; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        waitq(3);
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q / 2);
        b = sda_line; waitq(Q / 2);
        scl_m = 1'b0;
    endtask

    // driver: queue the expected acknowledge, then clock the byte out
    task automatic send(logic [7:0] b, int exp_ack, string tag);
        logic a;
        exp_val_q.push_back(exp_ack);
        exp_tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        obs_q.push_back(a ? 0 : 1);
    endtask

    task automatic recv(logic [7:0] exp_b, logic master_ack, string tag);
        logic [7:0] r;
        exp_val_q.push_back(int'(exp_b));
        exp_tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            r[i] = b;
        end
        obs_q.push_back(int'(r));
        put_bit(!master_ack);
    endtask

    initial begin
        model[0] = 8'h81; model[1] = 8'hFF; model[2] = 8'h0F; model[3] = 8'hF0;
        model[4] = 8'hFF; model[5] = 8'hC3; model[6] = 8'h5A; model[7] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        waitq(5);

        // R1: defaults after reset
        check_regs("R1 reset default");
        check("R1 sda released", int'(sda_oe), 0);

        // R4/R2: byte write of register 3
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h83, 1, "R4 command ack");
        waitq(5);
        check_regs("R12 unchanged before data");
        send(8'h3C, 1, "R4 data ack");
        bus_stop_cond();
        model[3] = 8'h3C;
        check_regs("R4 byte write");
        check("R11 released after stop", int'(sda_oe), 0);

        // R5: byte reads at two offsets
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h83, 1, "R5 command ack");
        bus_start_cond();
        send(8'hD3, 1, "R2 read address ack");
        recv(8'h3C, 1'b0, "R5 byte read reg3");
        bus_stop_cond();
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h86, 1, "R5 command ack");
        bus_start_cond();
        send(8'hD3, 1, "R2 read address ack");
        recv(8'h5A, 1'b0, "R5 byte read reg6");
        bus_stop_cond();

        // R3: foreign address ignored until next start
        bus_start_cond();
        send(8'hA4, 0, "R3 foreign address nack");
        send(8'h83, 0, "R3 ignored byte nack");
        send(8'h11, 0, "R3 ignored byte nack");
        check("R3 sda released while ignoring", int'(sda_oe), 0);
        bus_stop_cond();
        check_regs("R3 no write");

        // R6/R9: block write of three bytes then early stop
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h00, 1, "R6 block command ack");
        send(8'h03, 1, "R6 count ack");
        send(8'h11, 1, "R6 data ack");
        send(8'h22, 1, "R6 data ack");
        send(8'h33, 1, "R9 data ack before stop");
        bus_stop_cond();
        model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
        check_regs("R9 early stop keeps writes");

        // R7/R10: block read with count, then one byte past the end
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h00, 1, "R7 block command ack");
        bus_start_cond();
        send(8'hD3, 1, "R2 read address ack");
        recv(8'(NUM_REGS), 1'b1, "R7 count byte");
        for (int i = 0; i < NUM_REGS; i++) recv(model[i], 1'b1, "R7 block read data");
        recv(model[0], 1'b0, "R10 read wraps to reg0");
        bus_stop_cond();

        // R10: block write past the last register
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h00, 1, "R10 block command ack");
        send(8'h0A, 1, "R10 count ack");
        for (int i = 0; i < NUM_REGS + 2; i++) begin
            send(8'(8'h50 + 2 * i), 1, "R10 data ack incl past end");
        end
        bus_stop_cond();
        for (int i = 0; i < NUM_REGS; i++) model[i] = 8'(8'h50 + 2 * i);
        check_regs("R10 wrapped writes discarded");

        // R8: set skip bit, then count-less block write and read
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h87, 1, "R8 command ack");
        send(8'h01, 1, "R8 skip bit data ack");
        bus_stop_cond();
        model[7] = 8'h01;
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h00, 1, "R8 block command ack");
        send(8'h77, 1, "R8 first data ack");
        send(8'h66, 1, "R8 second data ack");
        bus_stop_cond();
        model[0] = 8'h77; model[1] = 8'h66;
        check_regs("R8 no count on write");
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h00, 1, "R8 block command ack");
        bus_start_cond();
        send(8'hD3, 1, "R2 read address ack");
        recv(8'h77, 1'b1, "R8 read starts at reg0");
        recv(8'h66, 1'b0, "R8 read reg1");
        bus_stop_cond();

        // R10: offset beyond the bank
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h8A, 1, "R10 out of range command ack");
        send(8'h99, 1, "R10 out of range data ack");
        bus_stop_cond();
        check_regs("R10 out of range write discarded");
        bus_start_cond();
        send(8'hD2, 1, "R2 write address ack");
        send(8'h8A, 1, "R10 out of range command ack");
        bus_start_cond();
        send(8'hD3, 1, "R2 read address ack");
        recv(8'h00, 1'b0, "R10 out of range read zero");
        bus_stop_cond();
        check("R11 released at end", int'(sda_oe), 0);

        while (obs_q.size() != 0) @(negedge clk);
        waitq(2);
        finish_run();
    end

endmodule